// File: doc/BRIEF.md
# Strobe-Latched Single-Bit Static Memory

This block is a 1024-word by 1-bit static memory. A cycle begins on the falling edge of an active-low enable strobe, not on a free-running clock. The whole block runs in one system clock domain. It samples the enable, the write enable, two active-low selects, the address and the data input on every clock edge, and it finds the strobe edges itself by comparing each sample with the one taken before it.

The falling edge of the enable captures the address. While the enable stays low, the location can be read, written, or read, modified and written back, and a write lands when its window closes. The rising edge of the enable freezes the output value. The two selects can then park the output in high impedance and release it again. The next falling edge starts a fresh cycle.

The three-state buffer is modelled as an output-enable flag. The data bit is driven to zero whenever that flag is low, so the bit and the flag together can stand for a shared data bus.

Top module: `strobe_sram`

## Requirements
- R1: The address pins are captured on the clock where the enable is first seen low after being high. Later changes on the address pins have no effect until the enable next falls.
- R2: A write window is open only while the enable and the write enable are both low. The array location is updated on the clock where the window closes, whichever of the two signals rises first, with the data input sampled on that clock. Write-enable pulses while the enable is high change nothing.
- R3: With the write enable held low across several back-to-back enable cycles, each cycle writes its own captured location, and each write closes on that cycle's enable rise.
- R4: When the enable is low, the write enable is high and both selects are low on a sampled clock, the output-enable flag is high after that clock and the data bit shows the stored bit of the captured location. If either select is high, the flag stays low.
- R5: Within one enable-low period, a write closed by the write enable's rise is visible on the output one clock later. The location may be rewritten any number of times, and the last closed write wins.
- R6: When the enable rises, the output value is frozen. While the enable stays high, it is driven whenever both selects are low and the write enable is high.
- R7: Either select high forces the output-enable flag low. Both selects low again restore the frozen value.
- R8: The next enable fall releases the frozen value and presents the newly captured location.
- R9: A sampled low write enable makes the output-enable flag low after that clock.
- R10: The data bit is zero whenever the output-enable flag is low.
- R11: Synchronous reset, active high, clears the edge history, the captured address and the frozen state and leaves the output-enable flag low. It does not clear the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en_n | input | 1 | Enable strobe, active low |
| we_n | input | 1 | Write enable, active low |
| sel_a_n | input | 1 | First output select, active low |
| sel_b_n | input | 1 | Second output select, active low |
| addr | input | ADDR_W | Word address |
| din | input | 1 | Write data |
| dout | output | 1 | Read data, zero when not driven |
| dout_oe | output | 1 | Output-enable flag standing for the three-state buffer |

## Verification
Every result is due one clock after the inputs that cause it are sampled. The strobe edge, the write commit and the output registers all act on the same edge that samples the inputs, and the array port is write-first. The bench drives inputs on the falling clock edge and queues one expected item for each driven cycle. Its monitor pops that item one time unit after the next rising edge, so every comparison lands in the cycle where the result first appears. Write, hold, select and reset cases are all checked with this one-cycle spacing.

// File: rtl/strobe_sram_pkg.sv
package strobe_sram_pkg;
  localparam int unsigned SRAM_ADDR_W_DEF = 10;

  // sampled gating conditions for the output stage
  typedef struct packed {
    logic rd_ok;
    logic sel_ok;
    logic we_hi;
  } gate_t;
endpackage

// File: rtl/strobe_ctrl.sv
module strobe_ctrl #(
  parameter int unsigned ADDR_W = strobe_sram_pkg::SRAM_ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              fall,
  output logic              rise,
  output logic              commit,
  output logic [ADDR_W-1:0] port_addr
);
  logic              en_q;
  logic              win_q;
  logic [ADDR_W-1:0] addr_q;
  logic              win;

  assign win       = !en_n && !we_n;
  assign fall      = en_q && !en_n;
  assign rise      = !en_q && en_n;
  assign commit    = win_q && !win;
  assign port_addr = fall ? addr : addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b1;
      win_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q  <= en_n;
      win_q <= win;
      if (fall) addr_q <= addr;
    end
  end

  // R1: inside one enable-low period the array port address does not move
  a_r1_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (!en_n && $past(!en_n) && !$past(rst)) |-> (port_addr == $past(port_addr)));

  // R2: a commit is only reported when a window was open on the previous sample
  a_r2_commit_window: assert property (@(posedge clk) disable iff (rst)
    (commit && !$past(rst)) |-> $past(!en_n && !we_n));
endmodule

// File: rtl/sram_bit_array.sv
module sram_bit_array #(
  parameter int unsigned ADDR_W = strobe_sram_pkg::SRAM_ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] port_addr,
  input  logic              wr_bit,
  output logic              rd_q
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic mem [DEPTH];

  // single port, write-first, no reset on the storage
  always_ff @(posedge clk) begin
    if (wr) begin
      mem[port_addr] <= wr_bit;
      rd_q           <= wr_bit;
    end else begin
      rd_q <= mem[port_addr];
    end
  end

  // R5: a committed bit is seen on the port output right after the write
  a_r5_write_first: assert property (@(posedge clk) disable iff (rst)
    wr |=> (rd_q == $past(wr_bit)));
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
  import strobe_sram_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_n,
  input  logic we_n,
  input  logic sel_a_n,
  input  logic sel_b_n,
  input  logic fall,
  input  logic rise,
  input  logic rd_bit,
  output logic dout,
  output logic dout_oe
);
  gate_t gate_q;
  logic  held_q;
  logic  sel_ok;

  assign sel_ok = !sel_a_n && !sel_b_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
      gate_q <= '0;
    end else begin
      if (rise)      held_q <= 1'b1;
      else if (fall) held_q <= 1'b0;
      gate_q.rd_ok  <= !en_n && we_n && sel_ok;
      gate_q.sel_ok <= sel_ok;
      gate_q.we_hi  <= we_n;
    end
  end

  assign dout_oe = gate_q.rd_ok || (held_q && gate_q.sel_ok && gate_q.we_hi);
  assign dout    = dout_oe && rd_bit;

  // R8: a new strobe fall always drops the frozen value
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    fall |=> !held_q);

  // R6: the frozen state only appears after the enable was sampled high
  a_r6_hold_after_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(held_q) |-> $past(en_n));
endmodule

// File: rtl/strobe_sram.sv
module strobe_sram #(
  parameter int unsigned ADDR_W = strobe_sram_pkg::SRAM_ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_n,
  input  logic              we_n,
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe
);
  logic              fall;
  logic              rise;
  logic              commit;
  logic [ADDR_W-1:0] port_addr;
  logic              rd_bit;

  strobe_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst(rst), .en_n(en_n), .we_n(we_n), .addr(addr),
    .fall(fall), .rise(rise), .commit(commit), .port_addr(port_addr)
  );

  sram_bit_array #(.ADDR_W(ADDR_W)) array_i (
    .clk(clk), .rst(rst), .wr(commit), .port_addr(port_addr),
    .wr_bit(din), .rd_q(rd_bit)
  );

  sram_out_stage out_i (
    .clk(clk), .rst(rst), .en_n(en_n), .we_n(we_n),
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .fall(fall), .rise(rise),
    .rd_bit(rd_bit), .dout(dout), .dout_oe(dout_oe)
  );

  // R7: output only driven if both selects were low on the sampled clock
  a_r7_sel_gate: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> $past(!sel_a_n && !sel_b_n));

  // R9: a low write enable keeps the output disabled
  a_r9_we_gate: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> $past(we_n));

  // R4: full read conditions always enable the output
  a_r4_read_drives: assert property (@(posedge clk) disable iff (rst)
    ($past(!en_n && we_n && !sel_a_n && !sel_b_n) && !$past(rst)) |-> dout_oe);
endmodule

// File: tb/strobe_sram_tb_top.sv
`timescale 1ns/1ps
module strobe_sram_tb_top;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en_n = 1'b1;
  logic          we_n = 1'b1;
  logic          sel_a_n = 1'b1;
  logic          sel_b_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          din = 1'b0;
  logic          dout;
  logic          dout_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    bit    chk;
    logic  oe;
    logic  d;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  always #5 clk = ~clk;

  strobe_sram #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .en_n(en_n), .we_n(we_n),
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .addr(addr), .din(din),
    .dout(dout), .dout_oe(dout_oe)
  );

  // driver: apply one cycle of inputs and queue the result due after the next edge
  task automatic drv(input logic r, input logic e, input logic w,
                     input logic sa, input logic sb, input int a, input logic d,
                     input logic xo, input logic xd, input string tag);
    exp_t it;
    @(negedge clk);
    rst = r; en_n = e; we_n = w; sel_a_n = sa; sel_b_n = sb;
    addr = AW'(a); din = d;
    it.chk = 1'b1; it.oe = xo; it.d = xd; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // monitor: compare one time unit after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        if (it.chk) begin
          checks++;
          if (dout_oe !== it.oe || dout !== it.d) begin
            errors++;
            $display("FAIL %s: oe=%b dout=%b expected oe=%b dout=%b",
                     it.tag, dout_oe, dout, it.oe, it.d);
          end
        end
      end
    end
  end

  initial begin
    drv(1,1,1,1,1,0,0, 0,0, "R11 reset state");
    drv(1,1,1,1,1,0,0, 0,0, "R11 reset state");
    drv(0,1,1,0,0,0,0, 0,0, "R11 idle after reset");
    // write 1 to word 5
    drv(0,0,0,0,0,5,0, 0,0, "R9 write open");
    drv(0,0,0,0,0,9,1, 0,0, "R9 R1 write open addr moved");
    drv(0,1,0,0,0,9,1, 0,0, "R9 close by enable rise");
    drv(0,1,1,0,0,9,0, 1,1, "R2 R6 frozen word5");
    // back-to-back writes, write enable held low
    drv(0,0,0,0,0,9,0, 0,0, "R3 cycle1 open");
    drv(0,1,0,0,0,9,0, 0,0, "R3 cycle1 close");
    drv(0,0,0,0,0,7,1, 0,0, "R3 cycle2 open");
    drv(0,1,0,0,0,7,1, 0,0, "R3 cycle2 close");
    drv(0,1,1,0,0,0,0, 1,1, "R3 frozen word7");
    drv(0,0,1,0,0,9,0, 1,0, "R3 R4 read word9");
    drv(0,1,1,0,0,9,0, 1,0, "R6 frozen word9");
    drv(0,0,1,0,0,7,0, 1,1, "R4 read word7");
    drv(0,0,1,0,0,9,0, 1,1, "R1 address pins ignored");
    // read-modify-write on word 7
    drv(0,0,0,0,0,9,0, 0,0, "R9 rmw write open");
    drv(0,0,1,0,0,9,0, 1,0, "R5 rmw new value");
    drv(0,0,0,0,0,9,1, 0,0, "R9 rewrite open");
    drv(0,0,0,0,0,9,0, 0,0, "R9 rewrite data moves");
    drv(0,0,0,0,0,9,1, 0,0, "R9 rewrite data moves");
    drv(0,0,1,0,0,9,1, 1,1, "R5 last write wins");
    drv(0,1,1,0,0,9,0, 1,1, "R6 frozen after rmw");
    drv(0,1,1,1,0,9,0, 0,0, "R7 R10 select a high");
    drv(0,1,1,0,1,9,0, 0,0, "R7 R10 select b high");
    drv(0,1,1,0,0,9,0, 1,1, "R7 selects restore");
    drv(0,1,0,0,0,9,0, 0,0, "R9 frozen with write enable low");
    drv(0,1,1,0,0,9,0, 1,1, "R2 no write while enable high");
    // read with a select high, then release
    drv(0,0,1,0,1,5,0, 0,0, "R4 R7 read deselected");
    drv(0,0,1,0,0,5,0, 1,1, "R4 read word5");
    drv(0,1,1,0,0,5,0, 1,1, "R6 frozen word5");
    drv(0,0,1,0,0,9,0, 1,0, "R8 new cycle word9");
    drv(0,1,1,0,0,9,0, 1,0, "R6 frozen word9");
    // write closed by write-enable rise
    drv(0,0,0,0,0,3,1, 0,0, "R9 write word3 open");
    drv(0,0,1,0,0,3,1, 1,1, "R2 R5 close by write enable rise");
    drv(0,1,1,0,0,3,0, 1,1, "R6 frozen word3");
    // reset keeps the array, clears the frozen state
    drv(1,1,1,0,0,3,0, 0,0, "R11 reset clears output");
    drv(0,1,1,0,0,3,0, 0,0, "R11 frozen state gone");
    drv(0,0,1,0,0,5,0, 1,1, "R11 array kept word5");
    drv(0,0,1,0,0,9,0, 1,1, "R1 pins ignored after capture");
    drv(0,1,1,1,1,0,0, 0,0, "R7 R10 idle deselected");
    repeat (3) @(posedge clk);
    #2;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule